// File: doc/BRIEF.md
# Clock-Lane Word Alignment Controller

This block trains a 1:7 source-synchronous receiver onto word boundaries. The forwarded word clock runs at one seventh of the bit rate with a duty cycle of three bit times high and four low. One period of that lane, deserialized, therefore has exactly one correct rotation, and that rotation marks where each word starts. Every word cycle the controller compares the parallel clock-lane sample with that rotation.

On a mismatch it sends a one-cycle bitslip strobe. The strobe is shared by the clock lane and every data lane, so all lanes shift together. The controller then ignores the lane while the deserializers settle. After a long enough run of matching samples it declares lock. A shorter run of misses while locked drops lock and training starts again. If many slips in a row bring no match, it raises a training-failed flag and keeps slipping.

The block runs in the word-clock domain with a synchronous, active-high reset. The deserializer and delay primitives sit outside it.

Top module: `clklane_word_aligner`

## Requirements
- R1: The expected clock-lane sample is three ones followed by four zeros, with bit 6 as the earliest bit: `lane_sample == 7'b1110000`. A lane already in that rotation is never slipped.
- R2: While searching, each mismatching sample produces exactly one `bitslip` pulse of one cycle. The pulse is high in the cycle that follows the edge where the sample was taken.
- R3: After each `bitslip` pulse the next SETTLE_CYC (4) samples are ignored. On a lane that never matches, pulses repeat every SETTLE_CYC+1 (5) cycles.
- R4: `locked` rises at the edge that takes the LOCK_RUN-th (16th) consecutive matching evaluated sample. From reset release on an aligned lane, this is 16 cycles. After the last slip, it is 20 cycles after the pulse.
- R5: While locked, `bitslip` stays low. A run of fewer than UNLOCK_RUN (4) consecutive mismatches keeps `locked` high, and a single match restarts that run.
- R6: The UNLOCK_RUN-th consecutive mismatch while locked clears `locked` at that edge without a slip. The next mismatching sample then starts a new slip sequence, and the block locks again once the lane aligns.
- R7: `train_fail` is set at the same edge as the MAX_SLIPS-th (7th) consecutive slip with no matching sample in between. The slip count then restarts and slipping continues. The flag stays set until lock is reached and clears at that edge.
- R8: A synchronous reset clears `locked`, `train_fail`, `bitslip` and every internal counter, including from the locked state.
- R9: Starting from any of the seven rotations, the block issues exactly as many slips as are needed to reach the expected rotation, then locks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| lane_sample | input | WORD_W (7) | Parallel sample of the clock lane, bit 6 earliest |
| bitslip | output | 1 | One-cycle slip strobe shared by all lanes |
| locked | output | 1 | Word alignment achieved |
| train_fail | output | 1 | Seven consecutive slips gave no match |

## Verification
The bench builds the block with its default parameters: a 7-bit word with three high bits, a 4-cycle settle, a 16-match lock run, a 4-miss unlock run and a 7-slip failure limit. These small limits bring every counter boundary within reach in a few dozen cycles. That covers the exact 5-cycle slip spacing, the 20-cycle gap from the last slip to lock, the third and fourth consecutive miss, and the seventh and fourteenth slip. A model of the receiver rotates the clock pattern by one bit per strobe, so several starting rotations and the way the block recovers from a lost lock can be tested against slip counts worked out by hand.

// File: rtl/wca_pkg.sv
package wca_pkg;

    typedef enum logic [1:0] {
        ST_SEARCH = 2'd0,
        ST_SETTLE = 2'd1,
        ST_LOCKED = 2'd2
    } align_state_e;

    typedef struct packed {
        align_state_e state;
        logic         slip;
        logic         lock;
        logic         fail;
    } align_regs_t;

endpackage

// File: rtl/wca_pattern_match.sv
module wca_pattern_match #(
    parameter int WORD_W    = 7,
    parameter int HIGH_BITS = 3
) (
    input  logic [WORD_W-1:0] sample,
    output logic              match
);
    localparam int LOW_BITS = WORD_W - HIGH_BITS;

    logic [WORD_W-1:0] expected;

    // earliest bits sit at the top and carry the high phase
    for (genvar i = 0; i < WORD_W; i++) begin : g_exp
        if (i >= LOW_BITS) begin : g_hi
            assign expected[i] = 1'b1;
        end else begin : g_lo
            assign expected[i] = 1'b0;
        end
    end

    assign match = (sample == expected);
endmodule

// File: rtl/wca_run_counter.sv
module wca_run_counter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/clklane_word_aligner.sv
module clklane_word_aligner
    import wca_pkg::*;
#(
    parameter int WORD_W     = 7,
    parameter int HIGH_BITS  = 3,
    parameter int SETTLE_CYC = 4,
    parameter int LOCK_RUN   = 16,
    parameter int UNLOCK_RUN = 4,
    parameter int MAX_SLIPS  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] lane_sample,
    output logic              bitslip,
    output logic              locked,
    output logic              train_fail
);

    align_regs_t r_d, r_q;

    logic match;
    logic hit_clr, hit_inc, hit_last;
    logic miss_clr, miss_inc, miss_last;
    logic slip_clr, slip_inc, slip_last;
    logic wait_clr, wait_inc, wait_last;

    wca_pattern_match #(
        .WORD_W    (WORD_W),
        .HIGH_BITS (HIGH_BITS)
    ) u_match (
        .sample (lane_sample),
        .match  (match)
    );

    wca_run_counter #(.LIMIT(LOCK_RUN)) u_hit_run (
        .clk(clk), .rst(rst), .clr(hit_clr), .inc(hit_inc), .at_last(hit_last)
    );

    wca_run_counter #(.LIMIT(UNLOCK_RUN)) u_miss_run (
        .clk(clk), .rst(rst), .clr(miss_clr), .inc(miss_inc), .at_last(miss_last)
    );

    wca_run_counter #(.LIMIT(MAX_SLIPS)) u_slip_run (
        .clk(clk), .rst(rst), .clr(slip_clr), .inc(slip_inc), .at_last(slip_last)
    );

    wca_run_counter #(.LIMIT(SETTLE_CYC)) u_settle (
        .clk(clk), .rst(rst), .clr(wait_clr), .inc(wait_inc), .at_last(wait_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.slip = 1'b0;
        hit_clr  = 1'b0;
        hit_inc  = 1'b0;
        miss_clr = 1'b0;
        miss_inc = 1'b0;
        slip_clr = 1'b0;
        slip_inc = 1'b0;
        wait_clr = 1'b0;
        wait_inc = 1'b0;

        unique case (r_q.state)
            ST_SEARCH: begin
                if (match) begin
                    slip_clr = 1'b1;
                    if (hit_last) begin
                        r_d.state = ST_LOCKED;
                        r_d.lock  = 1'b1;
                        r_d.fail  = 1'b0;
                        hit_clr   = 1'b1;
                        miss_clr  = 1'b1;
                    end else begin
                        hit_inc = 1'b1;
                    end
                end else begin
                    hit_clr   = 1'b1;
                    r_d.slip  = 1'b1;
                    r_d.state = ST_SETTLE;
                    wait_clr  = 1'b1;
                    if (slip_last) begin
                        r_d.fail = 1'b1;
                        slip_clr = 1'b1;
                    end else begin
                        slip_inc = 1'b1;
                    end
                end
            end

            ST_SETTLE: begin
                if (wait_last) begin
                    r_d.state = ST_SEARCH;
                    wait_clr  = 1'b1;
                end else begin
                    wait_inc = 1'b1;
                end
            end

            ST_LOCKED: begin
                if (match) begin
                    miss_clr = 1'b1;
                end else if (miss_last) begin
                    r_d.state = ST_SEARCH;
                    r_d.lock  = 1'b0;
                    miss_clr  = 1'b1;
                    hit_clr   = 1'b1;
                    slip_clr  = 1'b1;
                end else begin
                    miss_inc = 1'b1;
                end
            end

            default: begin
                r_d.state = ST_SEARCH;
                r_d.lock  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{state: ST_SEARCH, slip: 1'b0, lock: 1'b0, fail: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign bitslip    = r_q.slip;
    assign locked     = r_q.lock;
    assign train_fail = r_q.fail;

endmodule

// File: rtl/clklane_word_aligner_chk.sv
module clklane_word_aligner_chk #(
    parameter int WORD_W     = 7,
    parameter int HIGH_BITS  = 3,
    parameter int SETTLE_CYC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [WORD_W-1:0] lane_sample,
    input logic              bitslip,
    input logic              locked,
    input logic              train_fail
);
    localparam logic [WORD_W-1:0] EXP =
        {{HIGH_BITS{1'b1}}, {(WORD_W-HIGH_BITS){1'b0}}};
    localparam int GW = $clog2(SETTLE_CYC + 2);
    localparam logic [GW-1:0] GAP_MAX = GW'(SETTLE_CYC + 1);

    logic [GW-1:0] gap_q;
    logic          rst_seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q <= GAP_MAX;
        end else if (bitslip) begin
            gap_q <= '0;
        end else if (gap_q < GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
        // R8
        if (rst_seen_q === 1'b1) begin
            reset_clear_chk: assert (!locked && !bitslip && !train_fail);
        end
    end

    // R2
    slip_single_chk: assert property (@(posedge clk) disable iff (rst)
        bitslip |=> !bitslip);

    // R3
    slip_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bitslip |-> gap_q >= GW'(SETTLE_CYC));

    // R5
    no_slip_locked_chk: assert property (@(posedge clk) disable iff (rst)
        locked |-> !bitslip);

    // R4
    lock_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(lane_sample) == EXP);

    // R6
    unlock_on_miss_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && !$past(rst)) |-> $past(lane_sample) != EXP);

    // R7
    fail_with_slip_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(train_fail) |-> bitslip);

endmodule

bind clklane_word_aligner clklane_word_aligner_chk #(
    .WORD_W     (WORD_W),
    .HIGH_BITS  (HIGH_BITS),
    .SETTLE_CYC (SETTLE_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .lane_sample (lane_sample),
    .bitslip     (bitslip),
    .locked      (locked),
    .train_fail  (train_fail)
);

// File: tb/clklane_word_aligner_test.sv
module clklane_word_aligner_test;

    localparam logic [6:0] PAT = 7'b1110000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] lane_sample;
    logic       bitslip, locked, train_fail;

    int   vectors = 0;
    int   errors  = 0;
    bit   done    = 1'b0;

    int   offset = 0;
    bit   load_en = 1'b0;
    int   load_val = 0;
    bit   corrupt_en = 1'b0;

    always #5 clk = ~clk;

    clklane_word_aligner uut (
        .clk         (clk),
        .rst         (rst),
        .lane_sample (lane_sample),
        .bitslip     (bitslip),
        .locked      (locked),
        .train_fail  (train_fail)
    );

    // receiver model: each strobe rotates the deserialized word by one bit
    function automatic logic [6:0] rot(input logic [6:0] p, input int n);
        logic [13:0] t;
        t = {p, p} << n;
        return t[13:7];
    endfunction

    always @(posedge clk) begin
        if (load_en)      offset <= load_val;
        else if (bitslip) offset <= (offset == 6) ? 0 : offset + 1;
    end

    assign lane_sample = corrupt_en ? 7'b0000000 : rot(PAT, offset);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int off, input bit bad);
        @(negedge clk);
        rst = 1'b1;
        corrupt_en = bad;
        load_val = off;
        load_en = 1'b1;
        repeat (3) @(negedge clk);
        load_en = 1'b0;
        rst = 1'b0;
    endtask

    task automatic wait_lock(input int bound, output int cyc);
        cyc = 0;
        while (!locked && cyc < bound) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    // R8, R4, R1
    task automatic t_reset_aligned();
        int slips = 0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!locked && !bitslip && !train_fail, "R8 outputs low in reset",
            {locked, bitslip, train_fail}, 0);
        do_reset(0, 1'b0);
        for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            if (bitslip) slips++;
            if (locked) break;
        end
        chk(!locked, "R4 not locked after 15 matches", locked, 0);
        @(negedge clk);
        chk(locked, "R4 locked after 16th match", locked, 1);
        chk(slips == 0, "R1 aligned lane never slipped", slips, 0);
    endtask

    // R2, R3, R4, R9
    task automatic t_offset(input int off);
        int slips = 0, first = -1, last = -1, cyc = 0;
        bit prev = 1'b0, gap_ok = 1'b1, wide = 1'b0;
        do_reset(off, 1'b0);
        while (!locked && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (bitslip) begin
                if (prev) wide = 1'b1;
                if (last >= 0 && cyc - last != 5) gap_ok = 1'b0;
                if (first < 0) first = cyc;
                last = cyc;
                slips++;
            end
            prev = bitslip;
        end
        chk(slips == (7 - off) % 7, "R9 slip count for start rotation", slips, (7 - off) % 7);
        chk(first == 1, "R2 first slip one cycle after first sample", first, 1);
        chk(!wide, "R2 slip pulse one cycle wide", wide, 0);
        chk(gap_ok, "R3 slips spaced by 5 cycles", gap_ok, 1);
        chk(locked && cyc - last == 20, "R4 lock 20 cycles after last slip", cyc - last, 20);
    endtask

    // R5, R6
    task automatic t_lock_loss();
        int cyc;
        bit slip_seen = 1'b0;
        do_reset(0, 1'b0);
        repeat (16) @(negedge clk);
        chk(locked, "R5 precondition locked", locked, 1);
        corrupt_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (bitslip) slip_seen = 1'b1;
        end
        chk(locked, "R5 lock held after 3 misses", locked, 1);
        corrupt_en = 1'b0;
        @(negedge clk);
        corrupt_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            if (bitslip) slip_seen = 1'b1;
        end
        chk(locked, "R5 match restarts miss run", locked, 1);
        chk(!slip_seen, "R5 no slip while locked", slip_seen, 0);
        @(negedge clk);
        chk(!locked, "R6 lock dropped on 4th miss", locked, 1'b0);
        chk(!bitslip, "R6 no slip at unlock edge", bitslip, 0);
        @(negedge clk);
        chk(bitslip, "R6 slip follows unlock", bitslip, 1);
        corrupt_en = 1'b0;
        wait_lock(400, cyc);
        chk(locked, "R6 relock after loss", locked, 1);
    endtask

    // R7
    task automatic t_fail();
        int slips = 0, cyc = 0;
        bit early = 1'b0;
        do_reset(0, 1'b1);
        while (slips < 14 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (bitslip) begin
                slips++;
                if (slips == 6) chk(!train_fail, "R7 no fail at 6th slip", train_fail, 0);
                if (slips == 7) chk(train_fail, "R7 fail at 7th slip", train_fail, 1);
            end else if (slips < 7 && train_fail) begin
                early = 1'b1;
            end
        end
        chk(!early, "R7 fail not raised early", early, 0);
        chk(slips == 14 && train_fail, "R7 slipping continues with fail set", slips, 14);
        corrupt_en = 1'b0;
        while (!locked && cyc < 800) begin
            chk(train_fail, "R7 fail held until lock", train_fail, 1);
            @(negedge clk);
            cyc++;
        end
        chk(locked && !train_fail, "R7 fail cleared at lock", train_fail, 0);
    endtask

    // R8
    task automatic t_mid_reset();
        do_reset(0, 1'b0);
        repeat (16) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!locked && !bitslip && !train_fail, "R8 reset clears lock",
            {locked, bitslip, train_fail}, 0);
        rst = 1'b0;
        repeat (15) @(negedge clk);
        chk(!locked, "R8 hit run cleared by reset", locked, 0);
        @(negedge clk);
        chk(locked, "R8 relock after reset", locked, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        t_reset_aligned();
        t_offset(3);
        t_offset(6);
        t_offset(1);
        t_lock_loss();
        t_fail();
        t_mid_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule